// File: doc/BRIEF.md
# Auxiliary-Channel Request Frame Builder

This block assembles the outgoing byte sequence of one auxiliary-channel request inside a small transmit buffer and then streams it to a line encoder. A request is loaded with a 4-bit command, a 20-bit address, a payload length and a start delay. The block writes a packed header into the buffer, collects payload bytes from the requester for write commands, and then waits in an armed state. The transmission itself begins only after a go strobe. Before sending, it acknowledges the transmitter's previous done flag and waits until that flag reads low.

The builder is a single state machine with seven states. IDLE waits for a load. A load whose length is within limit moves it to HDR, and an oversized load raises the error flag and stays in IDLE. HDR writes one header byte per cycle. After the last header byte, it moves to FILL for a write command with a nonzero length, and to ARMED in every other case. FILL accepts payload bytes until the frame is complete and then moves to ARMED. ARMED waits for go and then moves to ACK. ACK lasts one cycle, pulses the acknowledge and moves to WAITCLR. WAITCLR holds until the done input reads 0 and then moves to SEND. SEND streams the buffer with a valid/ready handshake and returns to IDLE after the last byte. The buffer write index restarts at 0 with every accepted load and advances by one for each stored byte.

Top module: `aux_req_framer`

## Requirements
- R1: After reset `busy`, `armed`, `tx_valid`, `pl_ready`, `done_ack` and `len_err` are 0, and `byte_cnt` and `start_delay` are 0.
- R2: The first transmitted byte carries the command in bits 7:4 and address bits 19:16 in bits 3:0.
- R3: The second byte is address bits 15:8, and the third byte is address bits 7:0.
- R4: When the length is nonzero, a fourth byte equal to length minus one follows the address. A zero length sends no such byte.
- R5: Commands 4'h8, 4'h0 and 4'h4 are writes, and their payload bytes (taken through `pl_valid`/`pl_ready` in arrival order) follow the header. Every other command is a read and sends no payload.
- R6: `byte_cnt` equals 3 for a zero length and 4 otherwise, plus the length for write commands. It is the exact number of bytes streamed.
- R7: `start_delay` presents the delay of the accepted load, updated in the same cycle as `byte_cnt`.
- R8: A load with length above MAX_PL (16) sets `len_err`, leaves `busy` at 0 and sends nothing. The next accepted load clears `len_err`.
- R9: A go strobe in ARMED gives a one-cycle `done_ack` pulse. No byte is offered while `tx_done` remains 1 after that pulse.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_valid` hold in the next cycle.
- R11: A go strobe outside ARMED is ignored: no `done_ack`, and `busy` stays 0 in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_load | input | 1 | Load strobe for a new request (IDLE only) |
| req_cmd | input | 4 | Request command |
| req_addr | input | 20 | Request address |
| req_len | input | LEN_W | Payload length in bytes |
| req_delay | input | DLY_W | Start delay value |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Builder accepts payload (FILL) |
| go | input | 1 | Start strobe |
| tx_done | input | 1 | Transmitter done flag |
| done_ack | output | 1 | Done acknowledge pulse |
| armed | output | 1 | Frame complete, waiting for go |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| byte_cnt | output | CNT_W | Total bytes of the frame |
| start_delay | output | DLY_W | Delay loaded with the count |
| busy | output | 1 | Any state other than IDLE |
| len_err | output | 1 | Last load rejected as too long |

## Verification
Frames are built for native write and read, plain and middle-of-transaction I2C writes and reads, zero length, a one-byte read and the full 16-byte payload. These cases separate the write/read classification, the presence of the length byte and the count arithmetic. Each frame is streamed under a repeating ready pattern that sometimes withholds ready, which exposes any byte skipped or repeated under back-pressure. The done flag stays high for several cycles after the acknowledge, so an early start is caught. Separate tests load a 17-byte length and send a go in IDLE to confirm that both are rejected.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_FILL,
        ST_ARMED,
        ST_ACK,
        ST_WAITCLR,
        ST_SEND
    } frm_state_e;

    // write-class commands: native write, I2C write, I2C write with MOT
    function automatic logic is_wr_cmd(input logic [3:0] cmd);
        return (cmd == 4'h8) || (cmd == 4'h0) || (cmd == 4'h4);
    endfunction

    function automatic int frame_bytes(input logic [3:0] cmd, input int len);
        int n;
        n = (len != 0) ? 4 : 3;
        if (is_wr_cmd(cmd)) n = n + len;
        return n;
    endfunction

endpackage

// File: rtl/aux_frm_hdr.sv
module aux_frm_hdr #(
    parameter int LEN_W = 8,
    parameter int CNT_W = 5
) (
    input  logic [3:0]       cmd,
    input  logic [19:0]      addr,
    input  logic [LEN_W-1:0] len,
    input  logic [CNT_W-1:0] idx,
    output logic [7:0]       hdr_byte,
    output logic [CNT_W-1:0] hdr_last
);
    logic [LEN_W-1:0] len_m1;

    assign len_m1   = len - LEN_W'(1);
    assign hdr_last = (len != '0) ? CNT_W'(3) : CNT_W'(2);

    always_comb begin
        unique case (idx)
            CNT_W'(0): hdr_byte = {cmd, addr[19:16]};
            CNT_W'(1): hdr_byte = addr[15:8];
            CNT_W'(2): hdr_byte = addr[7:0];
            default:   hdr_byte = len_m1[7:0];
        endcase
    end
endmodule

// File: rtl/aux_frm_buf.sv
module aux_frm_buf #(
    parameter int DEPTH = 20,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_idx,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
        end else if (clr_idx) begin
            wr_idx <= '0;
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            wr_idx <= wr_idx + CNT_W'(1);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk) begin
                if (wr_en && !clr_idx && (int'(wr_idx) == g)) mem[g] <= wr_data;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(rd_idx) == i) rd_data = mem[i];
        end
    end
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
    import aux_frm_pkg::*;
#(
    parameter int MAX_PL = 16,
    parameter int LEN_W  = 8,
    parameter int DLY_W  = 4,
    localparam int DEPTH = MAX_PL + 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_load,
    input  logic [3:0]       req_cmd,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DLY_W-1:0] req_delay,
    input  logic             pl_valid,
    input  logic [7:0]       pl_data,
    output logic             pl_ready,
    input  logic             go,
    input  logic             tx_done,
    output logic             done_ack,
    output logic             armed,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [DLY_W-1:0] start_delay,
    output logic             busy,
    output logic             len_err
);
    frm_state_e       st, nxt;
    logic [3:0]       cmd_q;
    logic [19:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q, rd_q, wr_idx, hdr_last;
    logic [DLY_W-1:0] dly_q;
    logic             err_q, len_ok, wr_q;
    logic             clr_idx, wr_en;
    logic [7:0]       wr_data, hdr_byte;

    assign len_ok = (int'(req_len) <= MAX_PL);

    aux_frm_hdr #(.LEN_W(LEN_W), .CNT_W(CNT_W)) hdr_i (
        .cmd(cmd_q), .addr(addr_q), .len(len_q), .idx(wr_idx),
        .hdr_byte(hdr_byte), .hdr_last(hdr_last)
    );

    aux_frm_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) buf_i (
        .clk(clk), .rst_n(rst_n), .clr_idx(clr_idx), .wr_en(wr_en),
        .wr_data(wr_data), .wr_idx(wr_idx), .rd_idx(rd_q), .rd_data(tx_data)
    );

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cmd_q  <= '0;
            addr_q <= '0;
            len_q  <= '0;
            dly_q  <= '0;
            cnt_q  <= '0;
            rd_q   <= '0;
            err_q  <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && req_load) begin
                err_q <= !len_ok;
                if (len_ok) begin
                    cmd_q  <= req_cmd;
                    addr_q <= req_addr;
                    len_q  <= req_len;
                    dly_q  <= req_delay;
                    wr_q   <= is_wr_cmd(req_cmd);
                    cnt_q  <= CNT_W'(frame_bytes(req_cmd, int'(req_len)));
                end
            end
            if (st == ST_WAITCLR) rd_q <= '0;
            else if (st == ST_SEND && tx_ready) rd_q <= rd_q + CNT_W'(1);
        end
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:    if (req_load && len_ok) nxt = ST_HDR;
            ST_HDR:     if (wr_idx == hdr_last)
                            nxt = (wr_q && len_q != '0) ? ST_FILL : ST_ARMED;
            ST_FILL:    if (pl_valid && wr_idx == cnt_q - CNT_W'(1)) nxt = ST_ARMED;
            ST_ARMED:   if (go) nxt = ST_ACK;
            ST_ACK:     nxt = ST_WAITCLR;
            ST_WAITCLR: if (!tx_done) nxt = ST_SEND;
            ST_SEND:    if (tx_ready && rd_q == cnt_q - CNT_W'(1)) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = (st != ST_IDLE);
        armed       = (st == ST_ARMED);
        pl_ready    = (st == ST_FILL);
        done_ack    = (st == ST_ACK);
        tx_valid    = (st == ST_SEND);
        clr_idx     = (st == ST_IDLE) && req_load && len_ok;
        wr_en       = (st == ST_HDR) || ((st == ST_FILL) && pl_valid);
        wr_data     = (st == ST_HDR) ? hdr_byte : pl_data;
        byte_cnt    = cnt_q;
        start_delay = dly_q;
        len_err     = err_q;
    end
endmodule

// File: rtl/aux_frm_chk.sv
module aux_frm_chk #(
    parameter int MAX_PL = 16,
    parameter int LEN_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_load,
    input logic [LEN_W-1:0] req_len,
    input logic             go,
    input logic             tx_done,
    input logic             done_ack,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             tx_ready,
    input logic             busy,
    input logic             len_err
);
    // R10
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_ack |=> !done_ack);

    // R9
    start_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(!tx_done));

    // R8
    len_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_load && int'(req_len) > MAX_PL) |=> (len_err && !busy));

    // R11
    idle_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go && !req_load) |=> (!done_ack && !busy));

    // R10
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);
endmodule

bind aux_req_framer aux_frm_chk #(.MAX_PL(MAX_PL), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_len(req_len),
    .go(go), .tx_done(tx_done), .done_ack(done_ack), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .busy(busy), .len_err(len_err)
);

// File: tb/aux_req_framer_tb.sv
`timescale 1ns/1ps
module aux_req_framer_tb_top;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_load = 1'b0;
    logic [3:0]       req_cmd = '0;
    logic [19:0]      req_addr = '0;
    logic [7:0]       req_len = '0;
    logic [3:0]       req_delay = '0;
    logic             pl_valid = 1'b0;
    logic [7:0]       pl_data = '0;
    logic             pl_ready;
    logic             go = 1'b0;
    logic             tx_done = 1'b0;
    logic             done_ack, armed, tx_valid, busy, len_err;
    logic [7:0]       tx_data;
    logic             tx_ready = 1'b0;
    logic [CNT_W-1:0] byte_cnt;
    logic [3:0]       start_delay;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    aux_req_framer dut_i (
        .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_delay(req_delay),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready), .go(go),
        .tx_done(tx_done), .done_ack(done_ack), .armed(armed),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .byte_cnt(byte_cnt), .start_delay(start_delay), .busy(busy),
        .len_err(len_err)
    );

    // cmd[40:37] addr[36:17] len[16:9] delay[8:5] expected count[4:0]
    localparam logic [40:0] VEC [0:5] = '{
        {4'h8, 20'h12345, 8'd3,  4'd2,  5'd7},
        {4'h9, 20'hABCDE, 8'd3,  4'd5,  5'd4},
        {4'h0, 20'h00050, 8'd0,  4'd0,  5'd3},
        {4'h1, 20'hFFFFF, 8'd16, 4'd15, 5'd4},
        {4'h4, 20'h0A0B0, 8'd16, 4'd9,  5'd20},
        {4'h5, 20'h00001, 8'd1,  4'd1,  5'd4}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [3:0] c,
                                            input logic [19:0] a, input logic [7:0] l);
        int hc;
        hc = (l != 0) ? 4 : 3;
        if (i == 0) return {c, a[19:16]};
        if (i == 1) return a[15:8];
        if (i == 2) return a[7:0];
        if (i == 3 && l != 0) return l - 8'd1;
        return 8'hA0 + 8'(i - hc);
    endfunction

    task automatic run_frame(input logic [40:0] v);
        logic [3:0]  c;
        logic [19:0] a;
        logic [7:0]  l;
        logic [7:0]  got [0:31];
        logic [7:0]  prev_d;
        bit          wr, prev_hold;
        int          k, n, cyc, g;
        c = v[40:37]; a = v[36:17]; l = v[16:9];
        wr = (c == 4'h8) || (c == 4'h0) || (c == 4'h4);
        @(negedge clk);
        req_load = 1'b1; req_cmd = c; req_addr = a; req_len = l; req_delay = v[8:5];
        @(negedge clk);
        req_load = 1'b0;
        k = 0; g = 0;
        while (!armed && g < 200) begin
            if (pl_ready) begin pl_valid = 1'b1; pl_data = 8'hA0 + 8'(k); end
            else pl_valid = 1'b0;
            @(negedge clk);
            if (pl_valid) k++;
            g++;
        end
        pl_valid = 1'b0;
        // R5 payload taken only for writes
        chk(k == (wr ? int'(l) : 0), "R5 payload bytes taken", k, wr ? int'(l) : 0);
        // R6 count, R7 delay
        chk(byte_cnt == v[4:0], "R6 byte_cnt", byte_cnt, v[4:0]);
        chk(start_delay == v[8:5], "R7 start_delay", start_delay, v[8:5]);
        tx_done = 1'b1;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(done_ack == 1'b1, "R9 done_ack pulse", done_ack, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!tx_valid && !done_ack, "R9 held while done high", tx_valid, 0);
        end
        tx_done = 1'b0;
        n = 0; cyc = 0; prev_hold = 0; prev_d = '0;
        @(negedge clk);
        while (busy && cyc < 400) begin
            if (prev_hold)
                chk(tx_valid && tx_data == prev_d, "R10 hold under back-pressure", tx_data, prev_d);
            tx_ready = (cyc % 3) != 1;
            if (tx_valid && tx_ready && n < 32) begin got[n] = tx_data; n++; end
            prev_hold = tx_valid && !tx_ready;
            prev_d = tx_data;
            @(negedge clk);
            cyc++;
        end
        tx_ready = 1'b0;
        chk(n == int'(v[4:0]), "R6 bytes streamed", n, v[4:0]);
        for (int i = 0; i < n; i++) begin
            if (i == 0) chk(got[i] == exp_byte(i, c, a, l), "R2 byte0", got[i], exp_byte(i, c, a, l));
            else if (i < 3) chk(got[i] == exp_byte(i, c, a, l), "R3 address byte", got[i], exp_byte(i, c, a, l));
            else if (i == 3 && l != 0) chk(got[i] == exp_byte(i, c, a, l), "R4 length byte", got[i], exp_byte(i, c, a, l));
            else chk(got[i] == exp_byte(i, c, a, l), "R5 payload byte", got[i], exp_byte(i, c, a, l));
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !armed && !tx_valid && !pl_ready && !done_ack && !len_err,
            "R1 reset flags", {busy, armed, tx_valid, pl_ready, done_ack, len_err}, 0);
        chk(byte_cnt == 0 && start_delay == 0, "R1 reset count", byte_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 6; i++) run_frame(VEC[i]);

        // R11 go in IDLE ignored
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(!done_ack && !busy, "R11 idle go ignored", {done_ack, busy}, 0);
        @(negedge clk);
        chk(!done_ack && !busy && !tx_valid, "R11 still idle", {done_ack, busy, tx_valid}, 0);

        // R8 oversized length rejected
        req_load = 1'b1; req_cmd = 4'h8; req_addr = 20'h55555; req_len = 8'd17; req_delay = 4'd3;
        @(negedge clk);
        req_load = 1'b0;
        chk(len_err == 1'b1, "R8 len_err set", len_err, 1);
        chk(!busy && !pl_ready, "R8 stays idle", busy, 0);
        repeat (3) @(negedge clk);
        chk(!tx_valid && !busy, "R8 nothing sent", tx_valid, 0);
        chk(byte_cnt == 5'd4, "R8 count unchanged", byte_cnt, 4);

        // R8 next accepted load clears error; R4 zero-length read
        run_frame({4'h9, 20'h00ABC, 8'd0, 4'd7, 5'd3});
        chk(len_err == 1'b0, "R8 len_err cleared", len_err, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule